// File: doc/BRIEF.md
# Calendar Alarm With Pulsed Interrupt

This block watches a running calendar (seconds, minutes, hours, day of month, month and weekday) and raises an alarm when the time matches a programmed pattern. Each of the six alarm bytes holds a 7-bit compare value and, in its top bit, a flag that includes that field in the comparison. Fields whose flag is clear play no part. This lets one pattern recur every minute (seconds only), every hour, every day, or once a year (month and below).

The comparison is taken once per second, on a one-cycle tick from the timekeeping logic. On a hit, a sticky status flag is set and the active-low interrupt line is driven. In single-event mode the line follows the status flag and stays low until software clears it. The clear can be an explicit write, or a status read when auto-clear is on. In pulsed mode every hit drives the line low for a fixed count of 32.768 kHz cycles, 250 ms by default. Hits are blocked in three cases: while the master enable is off, while the square-wave output is running, and while the part runs from its backup cell without the battery alarm permission.

Top module: `calendar_alarm`

## Requirements
- R1: Bit 7 of each alarm byte includes that field in the compare against bits 6:0; a field with bit 7 clear matches whatever the current value is.
- R2: With bit 7 clear in all six alarm bytes, no hit ever occurs.
- R3: Matching is evaluated only in a cycle where `tick_1hz` is 1; a matching time without the tick sets nothing.
- R4: With `pulse_mode` = 0, a hit sets `alm_flag` to 1 one clock after the tick cycle, and `irq_n` is 0 exactly while `alm_flag` is 1.
- R5: With `pulse_mode` = 1, a hit sets `alm_flag` and drives `irq_n` to 0 for exactly PULSE_CYCLES (default 8192) clocks, starting one clock after the tick cycle.
- R6: `status_clr` clears `alm_flag` at the next edge, but a hit in the same cycle keeps the flag set.
- R7: With `auto_clr` = 1, `status_rd` clears `alm_flag` and, in single-event mode, releases `irq_n` at the same edge; with `auto_clr` = 0, `status_rd` has no effect.
- R8: While `fout_active` is 1, no hit occurs.
- R9: While `on_battery` is 1, hits occur only if `batt_alarm_en` is 1.
- R10: While `alarm_en` is 0, no hit occurs.
- R11: After reset, `alm_flag` is 0 and `irq_n` is 1.
- R12: A hit while a pulse is still running restarts the pulse, so `irq_n` stays low for PULSE_CYCLES clocks after the latest hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle strobe when the time fields have advanced |
| now_sec | input | 7 | Current seconds |
| now_min | input | 7 | Current minutes |
| now_hour | input | 7 | Current hours |
| now_date | input | 7 | Current day of month |
| now_month | input | 7 | Current month |
| now_wday | input | 7 | Current weekday |
| alm_sec | input | 8 | Seconds alarm byte, bit 7 = compare enable |
| alm_min | input | 8 | Minutes alarm byte, bit 7 = compare enable |
| alm_hour | input | 8 | Hours alarm byte, bit 7 = compare enable |
| alm_date | input | 8 | Day-of-month alarm byte, bit 7 = compare enable |
| alm_month | input | 8 | Month alarm byte, bit 7 = compare enable |
| alm_wday | input | 8 | Weekday alarm byte, bit 7 = compare enable |
| alarm_en | input | 1 | Master alarm enable |
| pulse_mode | input | 1 | 0 = single-event level, 1 = recurring pulse |
| auto_clr | input | 1 | Status read clears the flag |
| fout_active | input | 1 | Square-wave output running; blocks hits |
| on_battery | input | 1 | Running from the backup cell |
| batt_alarm_en | input | 1 | Permit hits while on the backup cell |
| status_rd | input | 1 | Status register read strobe |
| status_clr | input | 1 | Software clear of the status flag |
| alm_flag | output | 1 | Sticky alarm status |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A wrong compare or gating state appears at `alm_flag` on the clock edge right after the tick, so every match pattern is judged one cycle after its tick. A pulse counter that loads the wrong value or fails to reload appears only at the far end of the pulse. It is found by counting `irq_n` low cycles through the full window, both for a lone hit and for a hit inside a running pulse. A clear or read path with the wrong priority shows up as the flag's value one edge after the strobe.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    localparam int NFIELD  = 6;
    localparam int FIELD_W = 7;

    typedef logic [FIELD_W-1:0] fval_t;

    typedef struct packed {
        logic  en;
        fval_t val;
    } alm_field_t;

    typedef enum logic {
        IRQ_SINGLE = 1'b0,
        IRQ_PULSED = 1'b1
    } irq_mode_e;

    typedef struct packed {
        logic master_en;
        logic fout_on;
        logic on_batt;
        logic batt_ok;
    } gate_t;

    function automatic logic field_hit(alm_field_t a, fval_t now);
        return (!a.en) || (a.val == now);
    endfunction

    function automatic logic gate_open(gate_t g);
        return g.master_en && !g.fout_on && (!g.on_batt || g.batt_ok);
    endfunction

endpackage

// File: rtl/alarm_match.sv
module alarm_match
    import alarm_pkg::*;
#(
    parameter int NF = NFIELD
) (
    input  alm_field_t [NF-1:0] alm,
    input  fval_t      [NF-1:0] now,
    output logic                any_en,
    output logic                all_hit
);
    logic [NF-1:0] hit_v;
    logic [NF-1:0] en_v;

    for (genvar i = 0; i < NF; i++) begin : g_field
        assign hit_v[i] = field_hit(alm[i], now[i]);
        assign en_v[i]  = alm[i].en;
    end

    assign any_en  = |en_v;
    assign all_hit = &hit_v;
endmodule

// File: rtl/alarm_status.sv
module alarm_status (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic sw_clr,
    input  logic rd_strobe,
    input  logic auto_clr,
    output logic flag
);
    logic clr_req;

    assign clr_req = sw_clr || (rd_strobe && auto_clr);

    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (evt)     flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end
endmodule

// File: rtl/alarm_pulse.sv
module alarm_pulse #(
    parameter int PULSE_CYCLES = 8192
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic active
);
    localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYCLES);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)           cnt <= '0;
        else if (fire)     cnt <= LOAD;
        else if (cnt != 0) cnt <= cnt - CNT_W'(1);
    end

    assign active = (cnt != 0);
endmodule

// File: rtl/calendar_alarm.sv
module calendar_alarm
    import alarm_pkg::*;
#(
    parameter int PULSE_CYCLES = 8192
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_1hz,
    input  logic [6:0] now_sec,
    input  logic [6:0] now_min,
    input  logic [6:0] now_hour,
    input  logic [6:0] now_date,
    input  logic [6:0] now_month,
    input  logic [6:0] now_wday,
    input  logic [7:0] alm_sec,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_hour,
    input  logic [7:0] alm_date,
    input  logic [7:0] alm_month,
    input  logic [7:0] alm_wday,
    input  logic       alarm_en,
    input  logic       pulse_mode,
    input  logic       auto_clr,
    input  logic       fout_active,
    input  logic       on_battery,
    input  logic       batt_alarm_en,
    input  logic       status_rd,
    input  logic       status_clr,
    output logic       alm_flag,
    output logic       irq_n
);
    alm_field_t [NFIELD-1:0] alm_v;
    fval_t      [NFIELD-1:0] now_v;
    gate_t                   gate;
    irq_mode_e               mode;
    logic                    any_en;
    logic                    all_hit;
    logic                    evt;
    logic                    pulse_on;

    // field order: 0 sec, 1 min, 2 hour, 3 date, 4 month, 5 weekday
    assign alm_v = {alm_wday, alm_month, alm_date, alm_hour, alm_min, alm_sec};
    assign now_v = {now_wday, now_month, now_date, now_hour, now_min, now_sec};

    assign gate = '{master_en: alarm_en, fout_on: fout_active,
                    on_batt: on_battery, batt_ok: batt_alarm_en};
    assign mode = irq_mode_e'(pulse_mode);

    alarm_match #(.NF(NFIELD)) u_match (
        .alm     (alm_v),
        .now     (now_v),
        .any_en  (any_en),
        .all_hit (all_hit)
    );

    assign evt = tick_1hz && gate_open(gate) && any_en && all_hit;

    alarm_status u_status (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .sw_clr    (status_clr),
        .rd_strobe (status_rd),
        .auto_clr  (auto_clr),
        .flag      (alm_flag)
    );

    alarm_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .fire   (evt && (mode == IRQ_PULSED)),
        .active (pulse_on)
    );

    always_comb begin
        unique case (mode)
            IRQ_SINGLE: irq_n = !alm_flag;
            IRQ_PULSED: irq_n = !pulse_on;
            default:    irq_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/calendar_alarm_chk.sv
module calendar_alarm_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick_1hz,
    input logic [7:0] alm_sec,
    input logic [7:0] alm_min,
    input logic [7:0] alm_hour,
    input logic [7:0] alm_date,
    input logic [7:0] alm_month,
    input logic [7:0] alm_wday,
    input logic       alarm_en,
    input logic       pulse_mode,
    input logic       auto_clr,
    input logic       fout_active,
    input logic       status_rd,
    input logic       status_clr,
    input logic       alm_flag,
    input logic       irq_n,
    input logic       evt
);
    // R11
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!alm_flag && irq_n));

    // R3
    tick_only_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_1hz |=> !$rose(alm_flag));

    // R2
    need_enable_chk: assert property (@(posedge clk) disable iff (rst)
        evt |-> (alm_sec[7] || alm_min[7] || alm_hour[7] ||
                 alm_date[7] || alm_month[7] || alm_wday[7]));

    // R4
    single_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!pulse_mode && alm_flag) |-> !irq_n);

    // R4
    single_high_chk: assert property (@(posedge clk) disable iff (rst)
        (!pulse_mode && !alm_flag) |-> irq_n);

    // R5
    pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse_mode && evt) |=> (!irq_n || !pulse_mode));

    // R6
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (status_clr && !evt) |=> !alm_flag);

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        evt |=> alm_flag);

    // R7
    read_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (status_rd && !auto_clr && !status_clr && alm_flag) |=> alm_flag);

    // R8
    fout_block_chk: assert property (@(posedge clk) disable iff (rst)
        fout_active |=> !$rose(alm_flag));

    // R10
    master_off_chk: assert property (@(posedge clk) disable iff (rst)
        !alarm_en |=> !$rose(alm_flag));
endmodule

bind calendar_alarm calendar_alarm_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick_1hz    (tick_1hz),
    .alm_sec     (alm_sec),
    .alm_min     (alm_min),
    .alm_hour    (alm_hour),
    .alm_date    (alm_date),
    .alm_month   (alm_month),
    .alm_wday    (alm_wday),
    .alarm_en    (alarm_en),
    .pulse_mode  (pulse_mode),
    .auto_clr    (auto_clr),
    .fout_active (fout_active),
    .status_rd   (status_rd),
    .status_clr  (status_clr),
    .alm_flag    (alm_flag),
    .irq_n       (irq_n),
    .evt         (evt)
);

// File: tb/calendar_alarm_test.sv
module calendar_alarm_test;
    localparam int CLK_PERIOD = 30;
    localparam int PULSE = 8192;

    typedef struct packed {
        logic [5:0][7:0] alm;   // [5] wday .. [0] sec
        logic [5:0][6:0] now;
        logic            hit;
    } vec_t;

    localparam logic [5:0][6:0] BASE = {7'd3, 7'd6, 7'd14, 7'd9, 7'd12, 7'd30};

    localparam vec_t VEC [0:7] = '{
        '{alm: {8'h00,8'h00,8'h00,8'h00,8'h00,8'h9E}, now: BASE, hit: 1'b1},
        '{alm: {8'h00,8'h00,8'h00,8'h00,8'h00,8'h9E},
          now: {7'd3,7'd6,7'd14,7'd9,7'd12,7'd31}, hit: 1'b0},
        '{alm: {8'h83,8'h86,8'h8E,8'h89,8'h8C,8'h9E}, now: BASE, hit: 1'b1},
        '{alm: {8'h83,8'h86,8'h8E,8'h89,8'h8C,8'h9E},
          now: {7'd3,7'd7,7'd14,7'd9,7'd12,7'd30}, hit: 1'b0},
        '{alm: {8'h03,8'h06,8'h0E,8'h09,8'h0C,8'h1E}, now: BASE, hit: 1'b0},
        '{alm: {8'h00,8'h00,8'h00,8'h89,8'h8C,8'h05}, now: BASE, hit: 1'b1},
        '{alm: {8'h83,8'h00,8'h00,8'h00,8'h00,8'h00}, now: BASE, hit: 1'b1},
        '{alm: {8'h00,8'h00,8'h8F,8'h00,8'h00,8'h00}, now: BASE, hit: 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_1hz = 1'b0;
    logic [6:0] now_sec, now_min, now_hour, now_date, now_month, now_wday;
    logic [7:0] alm_sec, alm_min, alm_hour, alm_date, alm_month, alm_wday;
    logic alarm_en = 1'b1, pulse_mode = 1'b0, auto_clr = 1'b0;
    logic fout_active = 1'b0, on_battery = 1'b0, batt_alarm_en = 1'b0;
    logic status_rd = 1'b0, status_clr = 1'b0;
    logic alm_flag, irq_n;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    calendar_alarm #(.PULSE_CYCLES(PULSE)) uut (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
        .now_date(now_date), .now_month(now_month), .now_wday(now_wday),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
        .alm_date(alm_date), .alm_month(alm_month), .alm_wday(alm_wday),
        .alarm_en(alarm_en), .pulse_mode(pulse_mode), .auto_clr(auto_clr),
        .fout_active(fout_active), .on_battery(on_battery),
        .batt_alarm_en(batt_alarm_en), .status_rd(status_rd),
        .status_clr(status_clr), .alm_flag(alm_flag), .irq_n(irq_n)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load(logic [5:0][7:0] a, logic [5:0][6:0] n);
        {alm_wday, alm_month, alm_date, alm_hour, alm_min, alm_sec} = a;
        {now_wday, now_month, now_date, now_hour, now_min, now_sec} = n;
    endtask

    task automatic tick_once();
        @(negedge clk) tick_1hz = 1'b1;
        @(negedge clk) tick_1hz = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk) status_clr = 1'b1;
        @(negedge clk) status_clr = 1'b0;
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (!irq_n && n < 20000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        load(VEC[2].alm, VEC[2].now);
        repeat (3) @(negedge clk);
        chk("R11 flag", alm_flag, 0);
        chk("R11 irq_n", irq_n, 1);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 flag after release", alm_flag, 0);

        // vector table: R1, R2, R4 match patterns in single-event mode
        for (int i = 0; i < 8; i++) begin
            load(VEC[i].alm, VEC[i].now);
            tick_once();
            chk($sformatf("R1/R2/R4 vec%0d flag", i), alm_flag, VEC[i].hit);
            chk($sformatf("R4 vec%0d irq_n", i), irq_n, !VEC[i].hit);
            clear_flag();
            chk($sformatf("R6 vec%0d cleared", i), alm_flag, 0);
        end

        load(VEC[2].alm, VEC[2].now);

        // R3: matching time without a tick
        repeat (20) @(negedge clk);
        chk("R3 no tick", alm_flag, 0);

        // R4: level held until cleared
        tick_once();
        repeat (50) @(negedge clk);
        chk("R4 held flag", alm_flag, 1);
        chk("R4 held irq_n", irq_n, 0);

        // R7: read without auto-clear has no effect
        @(negedge clk) status_rd = 1'b1;
        @(negedge clk) status_rd = 1'b0;
        chk("R7 read no autoclr", alm_flag, 1);
        chk("R7 read no autoclr irq_n", irq_n, 0);

        // R7: read with auto-clear
        auto_clr = 1'b1;
        @(negedge clk) status_rd = 1'b1;
        @(negedge clk) status_rd = 1'b0;
        chk("R7 autoclr flag", alm_flag, 0);
        chk("R7 autoclr irq_n", irq_n, 1);
        auto_clr = 1'b0;

        // R6: hit in the same cycle as the clear wins
        @(negedge clk) begin tick_1hz = 1'b1; status_clr = 1'b1; end
        @(negedge clk) begin tick_1hz = 1'b0; status_clr = 1'b0; end
        chk("R6 set wins", alm_flag, 1);
        clear_flag();
        chk("R6 clear", alm_flag, 0);
        chk("R6 clear irq_n", irq_n, 1);

        // R8: square-wave output blocks hits
        fout_active = 1'b1;
        tick_once();
        chk("R8 fout blocks", alm_flag, 0);
        fout_active = 1'b0;

        // R10: master enable off
        alarm_en = 1'b0;
        tick_once();
        chk("R10 master off", alm_flag, 0);
        alarm_en = 1'b1;

        // R9: battery gating
        on_battery = 1'b1;
        tick_once();
        chk("R9 battery blocked", alm_flag, 0);
        batt_alarm_en = 1'b1;
        tick_once();
        chk("R9 battery permitted", alm_flag, 1);
        on_battery = 1'b0;
        batt_alarm_en = 1'b0;
        clear_flag();

        // R5: pulse width
        pulse_mode = 1'b1;
        @(negedge clk);
        chk("R5 idle irq_n", irq_n, 1);
        tick_once();
        chk("R5 flag", alm_flag, 1);
        count_low(n);
        chk("R5 pulse width", n, PULSE);
        chk("R5 flag stays", alm_flag, 1);
        clear_flag();

        // R12: hit inside a running pulse restarts it
        tick_once();
        repeat (100) @(negedge clk);
        chk("R12 still low", irq_n, 0);
        tick_once();
        count_low(n);
        chk("R12 restart width", n, PULSE);

        done = 1;
        summary();
        $finish;
    end
endmodule